// File: doc/BRIEF.md
# Light-Load Pulse-Skip Mode Controller

This block is the digital mode logic of a buck regulator. It decides when the regulator stops fixed-frequency PWM switching and starts pulse-skipping at light load, and when it goes back. While in PWM mode it passes the PWM modulator's high-side gate demand through and drives the low side as its complement. The low side is never cut off at zero current, so the inductor current can go negative. Each switching cycle ends with a one-clock strobe. At that strobe the controller samples whether the low-side current crossed zero during the cycle. A run of `ZC_RUN` such cycles in a row, with no miss, moves it into skip mode.

In skip mode the controller makes its own high-side pulses. A pulse starts on a rising edge of the PWM clock. It ends when the output rises above the upper threshold or when the switch current reaches the skip peak limit, whichever comes first. The low side then conducts until the current reaches zero, and the oscillator is gated off while the output coasts down. When the output falls back to nominal, the oscillator is enabled again and the next clock rising edge starts a new pulse. If the output drops below the lower threshold, or the mode-select input forces PWM, the controller returns to PWM. The mode flag only changes at a cycle strobe and never while a skip pulse is on.

All comparator results reach the block as logic levels already synchronous to `clk_i`. The PWM clock is sampled as a level, and its rising edge is detected internally.

Top module: `skip_mode_ctrl`

## Requirements
- R1: While `force_pwm_i` is 1 the controller never enters skip mode. A strobe with `force_pwm_i` at 1 discards any zero-cross run counted so far.
- R2: In PWM mode, `skip_mode_o` becomes 1 in the clock after the strobe that completes `ZC_RUN` (default 8) consecutive strobes sampled with `zc_i` at 1. After only `ZC_RUN`-1 such strobes it stays 0.
- R3: A strobe sampled with `zc_i` at 0 restarts the run, so `ZC_RUN` further zero-cross strobes are then needed for entry.
- R4: In PWM mode `hs_on_o` equals `pwm_hs_i` and `ls_en_o` equals its inverse, whatever the value of `zc_i`. `hs_on_o` and `ls_en_o` are never 1 together.
- R5: In skip mode, a 0-to-1 change of `pwm_clk_i` between two clock samples, seen while waiting, sets `hs_on_o` in the next clock. In the waiting state, `hs_on_o` and `ls_en_o` are 0 and `clk_en_o` is 1.
- R6: While a skip pulse is on, `ov_hi_i` or `ipk_i` at 1 clears `hs_on_o` in the next clock.
- R7: After a skip pulse ends, `clk_en_o` is 0 and `hs_on_o` is 0. `ls_en_o` is 1 until `zc_i` is seen and stays 0 after that. Rising edges of `pwm_clk_i` are ignored in this state. `v_nom_i` at 1 sets `clk_en_o` back to 1 in the next clock, and the controller waits for a rising edge again.
- R8: In skip mode a pulse on `uv_lo_i`, or `force_pwm_i` at 1, requests exit. `skip_mode_o` falls in the clock after the next strobe that occurs while no skip pulse is on.
- R9: `skip_mode_o` changes only in the clock after a strobe and never falls while a skip pulse is on. After an exit, a full run of `ZC_RUN` zero-cross strobes is needed again.
- R10: After reset `skip_mode_o` is 0 and `clk_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_pwm_i | input | 1 | 1 forces PWM mode, 0 allows pulse-skipping |
| pwm_clk_i | input | 1 | PWM oscillator clock, sampled as a level |
| cyc_strobe_i | input | 1 | One-clock marker at each switching-cycle boundary |
| pwm_hs_i | input | 1 | High-side demand from the PWM modulator |
| zc_i | input | 1 | Low-side current zero-cross detected |
| ov_hi_i | input | 1 | Output above the upper threshold |
| v_nom_i | input | 1 | Output at or below nominal |
| uv_lo_i | input | 1 | Output below the lower threshold |
| ipk_i | input | 1 | Switch current at the skip peak limit |
| skip_mode_o | output | 1 | 1 while in pulse-skip mode |
| hs_on_o | output | 1 | High-side gate command |
| ls_en_o | output | 1 | Low-side enable |
| clk_en_o | output | 1 | Oscillator enable, 0 while the output coasts |

## Verification
The assertions assume that `cyc_strobe_i` is a single-clock pulse and that every comparator input is already synchronous to `clk_i`, so that each one is a clean level at each edge. They do not assume any order among the threshold flags. The stimulus drives every input away from the clock edge and holds each input for whole clocks. Its strobes are always one clock wide and separated by at least one idle clock. It raises comparator flags only in the states where a real converter could produce them, for example `v_nom_i` only while coasting.

// File: rtl/skip_pkg.sv
package skip_pkg;
  typedef enum logic [1:0] {
    SP_WAIT  = 2'd0,
    SP_ON    = 2'd1,
    SP_COAST = 2'd2
  } sp_state_e;
endpackage

// File: rtl/zc_run_counter.sv
module zc_run_counter #(
  parameter int ZC_RUN = 8,
  localparam int CNT_W = (ZC_RUN > 2) ? $clog2(ZC_RUN) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic zc_i,
  input  logic clear_i,
  output logic run_done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ZC_RUN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign run_done_o = strobe_i & zc_i & ~clear_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (strobe_i) begin
      if (!zc_i || cnt_q == LAST)       cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_miss_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !zc_i |=> cnt_q == '0);
  assert_force_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/skip_mode_fsm.sv
module skip_mode_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic run_done_i,
  input  logic force_pwm_i,
  input  logic uv_lo_i,
  input  logic pulse_on_i,
  output logic skip_o
);
  logic skip_q, exit_pend_q, exit_now;

  // exit deferred to a boundary with no pulse in flight
  assign exit_now = skip_q & strobe_i & ~pulse_on_i
                  & (exit_pend_q | uv_lo_i | force_pwm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q      <= 1'b0;
      exit_pend_q <= 1'b0;
    end else begin
      if (!skip_q)       skip_q <= run_done_i;
      else if (exit_now) skip_q <= 1'b0;

      if (!skip_q || exit_now) exit_pend_q <= 1'b0;
      else if (uv_lo_i)        exit_pend_q <= 1'b1;
    end
  end

  assign skip_o = skip_q;

  assert_mode_on_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(skip_q) |-> $past(strobe_i));
  assert_no_cut_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q && pulse_on_i |=> skip_q);
  assert_force_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !skip_q && force_pwm_i |=> !skip_q);
  assert_uv_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q && uv_lo_i && strobe_i && !pulse_on_i |=> !skip_q);
endmodule

// File: rtl/skip_pulse_gen.sv
module skip_pulse_gen
  import skip_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic skip_i,
  input  logic pwm_clk_i,
  input  logic ov_hi_i,
  input  logic ipk_i,
  input  logic v_nom_i,
  input  logic zc_i,
  output logic hs_o,
  output logic ls_o,
  output logic clk_en_o,
  output logic on_o
);
  sp_state_e state_q, state_d;
  logic clk_prev_q, rise, zc_done_q;

  assign rise = pwm_clk_i & ~clk_prev_q;

  always_comb begin
    state_d = state_q;
    if (!skip_i) state_d = SP_WAIT;
    else begin
      unique case (state_q)
        SP_WAIT:  if (rise)              state_d = SP_ON;
        SP_ON:    if (ov_hi_i || ipk_i)  state_d = SP_COAST;
        SP_COAST: if (v_nom_i)           state_d = SP_WAIT;
        default:                         state_d = SP_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SP_WAIT;
      clk_prev_q <= 1'b0;
      zc_done_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      clk_prev_q <= pwm_clk_i;
      zc_done_q  <= (state_q == SP_COAST) & (zc_done_q | zc_i);
    end
  end

  assign on_o     = (state_q == SP_ON);
  assign hs_o     = on_o;
  assign ls_o     = (state_q == SP_COAST) & ~zc_done_q & ~zc_i;
  assign clk_en_o = (state_q != SP_COAST);

  assert_rise_starts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_i && state_q == SP_WAIT && rise |=> state_q == SP_ON);
  assert_turn_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_i && state_q == SP_ON && (ov_hi_i || ipk_i) |=> state_q == SP_COAST);
  assert_ls_latched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SP_COAST && zc_i && !v_nom_i && skip_i |=> !ls_o);
endmodule

// File: rtl/skip_mode_ctrl.sv
module skip_mode_ctrl #(
  parameter int ZC_RUN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_pwm_i,
  input  logic pwm_clk_i,
  input  logic cyc_strobe_i,
  input  logic pwm_hs_i,
  input  logic zc_i,
  input  logic ov_hi_i,
  input  logic v_nom_i,
  input  logic uv_lo_i,
  input  logic ipk_i,
  output logic skip_mode_o,
  output logic hs_on_o,
  output logic ls_en_o,
  output logic clk_en_o
);
  logic skip, run_done, sp_hs, sp_ls, sp_clk_en, sp_on;

  zc_run_counter #(.ZC_RUN(ZC_RUN)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (cyc_strobe_i),
    .zc_i       (zc_i),
    .clear_i    (force_pwm_i | skip),
    .run_done_o (run_done)
  );

  skip_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (cyc_strobe_i),
    .run_done_i  (run_done),
    .force_pwm_i (force_pwm_i),
    .uv_lo_i     (uv_lo_i),
    .pulse_on_i  (sp_on),
    .skip_o      (skip)
  );

  skip_pulse_gen u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .skip_i    (skip),
    .pwm_clk_i (pwm_clk_i),
    .ov_hi_i   (ov_hi_i),
    .ipk_i     (ipk_i),
    .v_nom_i   (v_nom_i),
    .zc_i      (zc_i),
    .hs_o      (sp_hs),
    .ls_o      (sp_ls),
    .clk_en_o  (sp_clk_en),
    .on_o      (sp_on)
  );

  assign skip_mode_o = skip;
  assign hs_on_o     = skip ? sp_hs : pwm_hs_i;
  assign ls_en_o     = skip ? sp_ls : ~pwm_hs_i;
  assign clk_en_o    = skip ? sp_clk_en : 1'b1;

  assert_no_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_on_o && ls_en_o));
  assert_coast_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> !hs_on_o && skip_mode_o);
endmodule

// File: tb/skip_mode_ctrl_tb.sv
`timescale 1ns/1ps
module skip_mode_ctrl_tb_top;
  localparam int ZC_RUN = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic force_pwm = 0, pwm_clk = 0, strobe = 0, pwm_hs = 0;
  logic zc = 0, ov_hi = 0, v_nom = 0, uv_lo = 0, ipk = 0;
  logic skip_o, hs_o, ls_o, clken_o;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  skip_mode_ctrl #(.ZC_RUN(ZC_RUN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .force_pwm_i(force_pwm), .pwm_clk_i(pwm_clk),
    .cyc_strobe_i(strobe), .pwm_hs_i(pwm_hs), .zc_i(zc), .ov_hi_i(ov_hi),
    .v_nom_i(v_nom), .uv_lo_i(uv_lo), .ipk_i(ipk),
    .skip_mode_o(skip_o), .hs_on_o(hs_o), .ls_en_o(ls_o), .clk_en_o(clken_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // one switching cycle: strobe clock then idle clock
  task automatic cycle(input logic z);
    strobe = 1; zc = z; step();
    strobe = 0; zc = 0; step();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle(1'b1);
  endtask

  task automatic force_exit();
    force_pwm = 1; strobe = 1; step();
    strobe = 0; force_pwm = 0; step();
  endtask

  task automatic enter_skip();
    run(ZC_RUN);
  endtask

  task automatic fire_pulse();
    pwm_clk = 1; step(); pwm_clk = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1; step();
    chk(skip_o, 1'b0, "R10 skip after reset");
    chk(clken_o, 1'b1, "R10 clk_en after reset");

    // R4: PWM pass-through, zc ignored
    for (int v = 0; v < 4; v++) begin
      pwm_hs = v[0]; zc = v[1]; step();
      chk(hs_o, v[0], "R4 hs follows pwm");
      chk(ls_o, ~v[0], "R4 ls complement, no zc cut");
    end
    pwm_hs = 0; zc = 0;

    // R2/R3: sweep miss position
    for (int p = 0; p < ZC_RUN; p++) begin
      run(p);
      cycle(1'b0);
      chk(skip_o, 1'b0, "R3 no skip after miss");
      run(ZC_RUN - 1);
      chk(skip_o, 1'b0, "R2 no skip one short of run");
      cycle(1'b1);
      chk(skip_o, 1'b1, "R2 skip after full run");
      force_exit();
      chk(skip_o, 1'b0, "R8 force exit");
    end

    // R1: forced PWM blocks entry and clears run
    force_pwm = 1; run(ZC_RUN + 3);
    chk(skip_o, 1'b0, "R1 forced pwm holds");
    force_pwm = 0;
    run(5);
    force_pwm = 1; cycle(1'b1); force_pwm = 0;
    run(ZC_RUN - 1);
    chk(skip_o, 1'b0, "R1 force cleared partial run");
    cycle(1'b1);
    chk(skip_o, 1'b1, "R1 entry after fresh run");

    // R5/R6/R7 pulse cycle, three turn-off causes
    for (int c = 1; c < 4; c++) begin
      chk(hs_o, 1'b0, "R5 waiting hs low");
      chk(ls_o, 1'b0, "R5 waiting ls low");
      chk(clken_o, 1'b1, "R5 waiting clock enabled");
      fire_pulse();
      chk(hs_o, 1'b1, "R5 pulse on clock rise");
      step();
      chk(hs_o, 1'b1, "R6 pulse held without trip");
      ov_hi = c[0]; ipk = c[1]; step(); ov_hi = 0; ipk = 0;
      chk(hs_o, 1'b0, "R6 turn-off on trip");
      chk(clken_o, 1'b0, "R7 clock gated");
      chk(ls_o, 1'b1, "R7 ls conducts to zero");
      zc = 1; #1;
      chk(ls_o, 1'b0, "R7 ls off at zero-cross");
      step(); zc = 0; step();
      chk(ls_o, 1'b0, "R7 ls stays off");
      fire_pulse(); step();
      chk(hs_o, 1'b0, "R7 rise ignored while coasting");
      chk(clken_o, 1'b0, "R7 still gated");
      v_nom = 1; step(); v_nom = 0;
      chk(clken_o, 1'b1, "R7 clock back at nominal");
      chk(skip_o, 1'b1, "R9 mode held in skip");
    end

    // R8/R9: exit request during a pulse waits for pulse end
    fire_pulse();
    uv_lo = 1; step(); uv_lo = 0;
    step();
    chk(skip_o, 1'b1, "R9 no exit without strobe");
    strobe = 1; step(); strobe = 0;
    chk(skip_o, 1'b1, "R9 no exit while pulse on");
    chk(hs_o, 1'b1, "R9 pulse not truncated");
    ipk = 1; step(); ipk = 0;
    strobe = 1; step(); strobe = 0;
    chk(skip_o, 1'b0, "R8 exit at next strobe after pulse");
    pwm_hs = 1; #1;
    chk(hs_o, 1'b1, "R8 pwm pass-through restored");
    chk(clken_o, 1'b1, "R8 clock enabled in pwm");
    pwm_hs = 0; step();

    // R9: run restarts after exit
    run(ZC_RUN - 1);
    chk(skip_o, 1'b0, "R9 counter cleared by exit");
    cycle(1'b1);
    chk(skip_o, 1'b1, "R9 re-entry after full run");
    uv_lo = 1; strobe = 1; step(); uv_lo = 0; strobe = 0;
    chk(skip_o, 1'b0, "R8 uv exit with strobe in wait");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule